// File: doc/BRIEF.md
# Feature-Based DMA Channel Allocator

This block keeps track of which DMA channels are free and hands them out on request. A requester presents a mask of the feature classes it needs. The allocator intersects the free-channel bitmap with the fixed capability set of every requested class, and grants the lowest-numbered channel that survives. The granted channel is marked busy in the same clock edge. A second port returns channels to the pool. It rejects out-of-range indices and channels that are already free.

The free-channel bitmap is loaded from a parameter at reset. Channels outside that initial set count as owned elsewhere, and a release of one of them adds it to the pool. Only one operation is accepted per cycle, and a release takes precedence over an allocation. Each accepted operation produces a registered response one cycle later. The response carries a status code and a channel field.

Top module: `dma_chan_alloc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the free bitmap is loaded with parameter `INIT_FREE` (default: only channel 4 free) and `rsp_valid` goes low.
- R2: The candidate set is the free bitmap ANDed with the capability mask of each set bit of `req_feat`. The bit positions are: bit 0 fast (channels 2,3), bit 1 bulk (channel 0), bit 2 normal (channels 1 to 7), bit 3 lite (channels 8 to 14).
- R3: A request whose `req_feat` is all zeros takes every free channel as a candidate.
- R4: A non-empty candidate set grants its lowest-numbered channel with status OK (code 0) and marks that channel busy.
- R5: An empty candidate set answers status NOENT (code 1) with channel field 0 and leaves the free bitmap unchanged.
- R6: Releasing a busy channel below 15 answers OK (code 0), echoes the index and marks the channel free.
- R7: Releasing a channel that is already free answers IDRM (code 2), echoes the index and leaves the bitmap unchanged.
- R8: Releasing an index of 15 or above answers INVAL (code 3), echoes the index and leaves the bitmap unchanged.
- R9: An operation accepted at a clock edge raises `rsp_valid` for exactly the following cycle. `rsp_is_rel` is 1 for a release and 0 for an allocation. Without an accepted operation, `rsp_valid` stays low.
- R10: `rel_ready` is always 1. `req_ready` is low while `rel_valid` is high, so a simultaneous allocation waits and only the release is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Allocation request accepted this cycle |
| req_feat | input | FEAT_N | Required feature classes |
| rel_valid | input | 1 | Release request present |
| rel_ready | output | 1 | Release accepted (always 1) |
| rel_chan | input | CH_W | Channel index to release |
| rsp_valid | output | 1 | Response present |
| rsp_is_rel | output | 1 | 1: response to a release, 0: to an allocation |
| rsp_status | output | 2 | 0 OK, 1 NOENT, 2 IDRM, 3 INVAL |
| rsp_chan | output | CH_W | Granted or echoed channel index |

## Verification
On every cycle, the bound checker checks the following:
- the accept-to-response timing;
- that a grant lands on a channel now busy;
- that a successful release leaves the channel free;
- that the bitmap stays stable across NOENT, IDRM and INVAL answers;
- that the two ports are never accepted together.

Some properties can only be shown by the bench's scenarios:
- that the lowest-numbered candidate wins;
- that combined feature masks intersect correctly;
- that a class can be exhausted;
- that a released channel is granted again ahead of higher free channels.

// File: rtl/chan_alloc_pkg.sv
// Shared types for the DMA channel allocator.
// Assumes: status codes are a fixed 2-bit encoding seen by requesters.
package chan_alloc_pkg;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_NOENT = 2'd1,
        ST_IDRM  = 2'd2,
        ST_INVAL = 2'd3
    } alloc_status_e;

endpackage

// File: rtl/chan_feature_filter.sv
// Narrows the free bitmap to the channels that have every requested feature.
// Assumes: CAPS row f is the capability set of feature bit f.
module chan_feature_filter #(
    parameter int NUM_CH = 15,
    parameter int FEAT_N = 4,
    parameter logic [FEAT_N-1:0][NUM_CH-1:0] CAPS = '0
) (
    input  logic [NUM_CH-1:0] free_map,
    input  logic [FEAT_N-1:0] feat,
    output logic [NUM_CH-1:0] cand
);

    logic [FEAT_N-1:0][NUM_CH-1:0] term;

    // Each requested feature contributes its mask; unrequested ones pass all.
    for (genvar f = 0; f < FEAT_N; f++) begin : g_term
        assign term[f] = feat[f] ? CAPS[f] : {NUM_CH{1'b1}};
    end

    // AND all terms with the free bitmap.
    always_comb begin
        cand = free_map;
        for (int f = 0; f < FEAT_N; f++) begin
            cand = cand & term[f];
        end
    end

endmodule

// File: rtl/chan_lowest_pick.sv
// Finds the lowest set bit of a candidate vector.
// Assumes: idx is meaningful only when found is high.
module chan_lowest_pick #(
    parameter int NUM_CH = 15,
    parameter int CH_W   = 5
) (
    input  logic [NUM_CH-1:0] cand,
    output logic              found,
    output logic [CH_W-1:0]   idx
);

    // Scan downward so the lowest set bit is written last.
    always_comb begin
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (cand[i]) idx = CH_W'(i);
        end
        found = |cand;
    end

endmodule

// File: rtl/chan_free_bank.sv
// Holds the free-channel bitmap; applies one claim and one return mask per edge.
// Assumes: callers never claim and return the same channel in one cycle.
module chan_free_bank #(
    parameter int NUM_CH = 15,
    parameter logic [NUM_CH-1:0] INIT_FREE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] claim_mask,
    input  logic [NUM_CH-1:0] return_mask,
    output logic [NUM_CH-1:0] free_q
);

    // Reset load, then clear claimed bits and set returned bits.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= INIT_FREE;
        else        free_q <= (free_q & ~claim_mask) | return_mask;
    end

endmodule

// File: rtl/dma_chan_alloc.sv
// Top: feature-filtered DMA channel allocation and release with a registered response.
// Assumes: one operation per cycle; a release wins over a simultaneous allocation.
module dma_chan_alloc
    import chan_alloc_pkg::*;
#(
    parameter int NUM_CH = 15,
    parameter int FEAT_N = 4,
    parameter int CH_W   = $clog2(NUM_CH) + 1,
    parameter logic [NUM_CH-1:0] INIT_FREE  = 15'h0010,
    parameter logic [NUM_CH-1:0] CAP_FAST   = 15'h000C,
    parameter logic [NUM_CH-1:0] CAP_BULK   = 15'h0001,
    parameter logic [NUM_CH-1:0] CAP_NORMAL = 15'h00FE,
    parameter logic [NUM_CH-1:0] CAP_LITE   = 15'h7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FEAT_N-1:0] req_feat,
    input  logic              rel_valid,
    output logic              rel_ready,
    input  logic [CH_W-1:0]   rel_chan,
    output logic              rsp_valid,
    output logic              rsp_is_rel,
    output logic [1:0]        rsp_status,
    output logic [CH_W-1:0]   rsp_chan
);

    localparam logic [FEAT_N-1:0][NUM_CH-1:0] CAPS = {CAP_LITE, CAP_NORMAL, CAP_BULK, CAP_FAST};

    logic [NUM_CH-1:0] free_q;
    logic [NUM_CH-1:0] cand;
    logic [NUM_CH-1:0] claim_mask, return_mask, rel_onehot, grant_onehot;
    logic              found, acc_req, acc_rel, rel_in_range, rel_was_free;
    logic [CH_W-1:0]   pick_idx;
    alloc_status_e     nxt_status;
    logic [CH_W-1:0]   nxt_chan;

    chan_feature_filter #(.NUM_CH(NUM_CH), .FEAT_N(FEAT_N), .CAPS(CAPS)) u_filter (
        .free_map (free_q),
        .feat     (req_feat),
        .cand     (cand)
    );

    chan_lowest_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .cand  (cand),
        .found (found),
        .idx   (pick_idx)
    );

    chan_free_bank #(.NUM_CH(NUM_CH), .INIT_FREE(INIT_FREE)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .claim_mask  (claim_mask),
        .return_mask (return_mask),
        .free_q      (free_q)
    );

    // Handshake: releases always accepted, allocations only when no release is pending.
    assign rel_ready = 1'b1;
    assign req_ready = ~rel_valid;
    assign acc_rel   = rel_valid;
    assign acc_req   = req_valid & ~rel_valid;

    // Decode the release index and the grant into one-hot channel masks.
    always_comb begin
        rel_in_range = rel_chan < CH_W'(NUM_CH);
        rel_onehot   = rel_in_range ? (NUM_CH'(1) << rel_chan) : '0;
        rel_was_free = |(free_q & rel_onehot);
        grant_onehot = found ? (NUM_CH'(1) << pick_idx) : '0;
        claim_mask   = acc_req ? grant_onehot : '0;
        return_mask  = (acc_rel && !rel_was_free) ? rel_onehot : '0;
    end

    // Choose the status and channel field for the operation accepted this cycle.
    always_comb begin
        if (acc_rel) begin
            nxt_chan = rel_chan;
            if (!rel_in_range)     nxt_status = ST_INVAL;
            else if (rel_was_free) nxt_status = ST_IDRM;
            else                   nxt_status = ST_OK;
        end else begin
            nxt_chan   = found ? pick_idx : '0;
            nxt_status = found ? ST_OK : ST_NOENT;
        end
    end

    // Register the response for one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_is_rel <= 1'b0;
            rsp_status <= 2'd0;
            rsp_chan   <= '0;
        end else begin
            rsp_valid <= acc_req | acc_rel;
            if (acc_req | acc_rel) begin
                rsp_is_rel <= acc_rel;
                rsp_status <= nxt_status;
                rsp_chan   <= nxt_chan;
            end
        end
    end

endmodule

// File: rtl/dma_chan_alloc_chk.sv
// Checker bound to dma_chan_alloc: timing and bitmap-consistency properties.
// Assumes: free_q is the allocator's free-channel bitmap.
module dma_chan_alloc_chk #(
    parameter int NUM_CH = 15,
    parameter int CH_W   = 5,
    parameter logic [NUM_CH-1:0] INIT_FREE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rel_valid,
    input logic [CH_W-1:0]   rel_chan,
    input logic              rsp_valid,
    input logic              rsp_is_rel,
    input logic [1:0]        rsp_status,
    input logic [CH_W-1:0]   rsp_chan,
    input logic [NUM_CH-1:0] free_q
);

    logic accepted;
    logic rsp_bit_free;
    assign accepted     = (req_valid && req_ready) || rel_valid;
    assign rsp_bit_free = |(free_q & (NUM_CH'(1) << rsp_chan));

    p_reset_load_r1: assert property (@(posedge clk)
        !rst_n |=> (free_q == INIT_FREE && !rsp_valid));

    p_grant_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_rel && rsp_status == 2'd0) |-> !rsp_bit_free);

    p_noent_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_status != 2'd1 || $stable(free_q)));

    p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_is_rel && rsp_status == 2'd0) |-> rsp_bit_free);

    p_idrm_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> (rsp_status != 2'd2 || $stable(free_q)));

    p_inval_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && rel_chan >= CH_W'(NUM_CH)) |=> (rsp_status == 2'd3 && $stable(free_q)));

    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> rsp_valid);

    p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accepted |=> !rsp_valid);

    p_single_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel_valid && req_ready));

endmodule

bind dma_chan_alloc dma_chan_alloc_chk #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .INIT_FREE(INIT_FREE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rel_valid  (rel_valid),
    .rel_chan   (rel_chan),
    .rsp_valid  (rsp_valid),
    .rsp_is_rel (rsp_is_rel),
    .rsp_status (rsp_status),
    .rsp_chan   (rsp_chan),
    .free_q     (free_q)
);

// File: tb/dma_chan_alloc_tb.sv
module dma_chan_alloc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_feat = '0;
    logic       rel_valid = 1'b0;
    logic       rel_ready;
    logic [4:0] rel_chan = '0;
    logic       rsp_valid, rsp_is_rel;
    logic [1:0] rsp_status;
    logic [4:0] rsp_chan;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dma_chan_alloc u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_feat(req_feat),
        .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_chan(rel_chan),
        .rsp_valid(rsp_valid), .rsp_is_rel(rsp_is_rel),
        .rsp_status(rsp_status), .rsp_chan(rsp_chan)
    );

    // Entry: {req tag number(4), is_release(1), arg(5), status(2), chan(5)}.
    // Starts with channels 0..14 all free.
    localparam int NV = 27;
    localparam logic [16:0] VEC [NV] = '{
        {4'd7,  1'b1, 5'd3,  2'd2, 5'd3},   // R7 double free
        {4'd2,  1'b0, 5'd1,  2'd0, 5'd2},   // R2 fast
        {4'd2,  1'b0, 5'd1,  2'd0, 5'd3},   // R2 fast
        {4'd5,  1'b0, 5'd1,  2'd1, 5'd0},   // R5 fast exhausted
        {4'd2,  1'b0, 5'd2,  2'd0, 5'd0},   // R2 bulk
        {4'd5,  1'b0, 5'd2,  2'd1, 5'd0},   // R5 bulk exhausted
        {4'd4,  1'b0, 5'd4,  2'd0, 5'd1},   // R4 normal lowest
        {4'd4,  1'b0, 5'd4,  2'd0, 5'd4},   // R4 normal next
        {4'd5,  1'b0, 5'd5,  2'd1, 5'd0},   // R5 fast+normal empty
        {4'd2,  1'b0, 5'd8,  2'd0, 5'd8},   // R2 lite
        {4'd2,  1'b0, 5'd12, 2'd1, 5'd0},   // R2 disjoint classes
        {4'd6,  1'b1, 5'd2,  2'd0, 5'd2},   // R6 release
        {4'd4,  1'b0, 5'd5,  2'd0, 5'd2},   // R4 re-grant of released
        {4'd3,  1'b0, 5'd0,  2'd0, 5'd5},   // R3 any free
        {4'd8,  1'b1, 5'd15, 2'd3, 5'd15},  // R8
        {4'd8,  1'b1, 5'd31, 2'd3, 5'd31},  // R8
        {4'd6,  1'b1, 5'd1,  2'd0, 5'd1},   // R6
        {4'd7,  1'b1, 5'd1,  2'd2, 5'd1},   // R7
        {4'd4,  1'b0, 5'd0,  2'd0, 5'd1},   // R4 lowest after release
        {4'd2,  1'b0, 5'd8,  2'd0, 5'd9},
        {4'd2,  1'b0, 5'd8,  2'd0, 5'd10},
        {4'd2,  1'b0, 5'd8,  2'd0, 5'd11},
        {4'd2,  1'b0, 5'd8,  2'd0, 5'd12},
        {4'd2,  1'b0, 5'd8,  2'd0, 5'd13},
        {4'd2,  1'b0, 5'd8,  2'd0, 5'd14},
        {4'd5,  1'b0, 5'd8,  2'd1, 5'd0},   // R5 lite exhausted
        {4'd3,  1'b0, 5'd0,  2'd0, 5'd6}    // R3 remaining normal-only
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One operation: drive at negedge, accepted at posedge, sample at next negedge.
    task automatic op(input logic is_rel, input logic [4:0] arg,
                      input logic [1:0] est, input logic [4:0] ech, input string tag);
        req_valid = !is_rel;
        rel_valid = is_rel;
        req_feat  = arg[3:0];
        rel_chan  = arg;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rel_valid = 1'b0;
        check({tag, " rsp"}, {rsp_valid, rsp_is_rel, rsp_status, 4'd0}, {1'b1, is_rel, est, 4'd0});
        check({tag, " chan"}, {3'd0, rsp_chan}, {3'd0, ech});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no response after reset
        check("R1 idle", {7'd0, rsp_valid}, 8'd0);
        // R1: only channel 4 free after reset
        op(1'b0, 5'd0, 2'd0, 5'd4, "R1 init grant");
        op(1'b0, 5'd0, 2'd1, 5'd0, "R5 pool empty");
        // R6: returning channels owned elsewhere fills the pool
        for (int c = 0; c < 15; c++) op(1'b1, 5'(c), 2'd0, 5'(c), "R6 fill");
        for (int v = 0; v < NV; v++) begin
            op(VEC[v][12], VEC[v][11:7], VEC[v][6:5], VEC[v][4:0],
               $sformatf("R%0d vec%0d", VEC[v][16:13], v));
        end
        // R9: response lasts one cycle
        @(negedge clk);
        check("R9 pulse", {7'd0, rsp_valid}, 8'd0);
        // R10: both ports at once, only the release is answered
        req_valid = 1'b1; req_feat = 4'd8;
        rel_valid = 1'b1; rel_chan = 5'd9;
        #1;
        check("R10 ready", {6'd0, req_ready, rel_ready}, 8'b01);
        @(posedge clk); @(negedge clk);
        rel_valid = 1'b0;
        check("R10 rsp", {rsp_valid, rsp_is_rel, rsp_status, 4'd0}, {1'b1, 1'b1, 2'd0, 4'd0});
        // waiting allocation now taken: released 9 is the only lite channel
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check("R10 deferred", {rsp_valid, rsp_is_rel, rsp_status, rsp_chan[3:0]}, {1'b1, 1'b0, 2'd0, 4'd9});
        // R1: mid-run reset restores the initial map
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rsp", {7'd0, rsp_valid}, 8'd0);
        op(1'b0, 5'd4, 2'd0, 5'd4, "R1 reload");
        op(1'b0, 5'd0, 2'd1, 5'd0, "R1 reload empty");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule